// File: doc/BRIEF.md
# Ramped Digital Attenuator Controller

This block holds the present attenuation code of one audio path. It walks that code toward a target one code (1 dB) at a time, at a pace set by a 3-bit step-time selector counted in sample periods. The target is normally a 7-bit level input. In fixed mode the target is pinned at unity gain. While a mute request is held, or while the sample clock is flagged as out of sync, the target becomes silence. When that condition clears, the code walks back to the level that was set. The mapping is gain in dB = code − 121. Codes 0x00 through 0x14 all mean silence (−∞), and a walk upward out of silence lands on 0x15 (−100 dB) first.

The same block scales a stream of signed samples by the gain of the current code. It uses a six-entry 1 dB mantissa table and an arithmetic shift per 6 dB. Samples enter and leave through valid/ready handshakes with a single output register between them:
- An input sample is taken in a cycle where `in_valid` and `in_ready` are both high. It is scaled with the code held in that cycle.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- Once `out_valid` is high, it and `out_sample` hold unchanged until `out_ready` takes the sample.

The ramp logic itself has no handshake. It advances only on the `sample_tick` pulse, which is high for one clock per sample period.

Top module: `ramp_atten`

## Requirements
- R1: The gain in dB of a code c is c − 121: 0x79 is unity, 0x7F is +6 dB, 0x73 is −6 dB, and 0x15 is −100 dB.
- R2: `level_silent` is high exactly when `level_code` is 0x14 or lower.
- R3: After reset, `level_code` is 0x00 and `level_silent` is high.
- R4: While `fixed_unity` is high (and neither mute nor sync loss applies), the target is 0x79 and `level_target` has no effect.
- R5: A step upward from a silent code goes straight to 0x15. Every other step moves the code by exactly one toward the target. A downward step that would reach 0x14 or below goes straight to the target.
- R6: With `step_sel` = n, one step occurs on every 2^n-th `sample_tick` (n = 0 gives a step per tick, n = 7 gives one per 128 ticks), and the code never changes in a cycle that follows no tick.
- R7: While `mute_req` is high, the target is 0x00. When it is released, the code ramps back to the previously set target.
- R8: While `sync_ok` is low, the target is 0x00. When sync returns, the code ramps back to the set target.
- R9: An accepted sample s at a non-silent code c gives `out_sample` = floor(s·M[r] / 2^(14+q)), saturated to the signed 18-bit range. Here a = 127 − c, q = a / 6, r = a mod 6, and M = {32768, 29205, 26029, 23198, 20675, 18427}.
- R10: An accepted sample at a silent code gives `out_sample` = 0.
- R11: `out_valid` and `out_sample` stay stable while `out_ready` is low, and `in_ready` is then low.
- R12: Any change of the effective target restarts the step interval, so the next step needs a full 2^n ticks after the change. The step direction is chosen again at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-clock pulse per sample period |
| level_target | input | 7 | Programmed attenuation code |
| step_sel | input | 3 | Step interval select, 2^n ticks per step |
| mute_req | input | 1 | High forces a ramp to silence |
| sync_ok | input | 1 | Low (sync lost) forces a ramp to silence |
| fixed_unity | input | 1 | High pins the target at 0x79 |
| level_code | output | 7 | Current attenuation code |
| level_silent | output | 1 | Current code is −∞ |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample may be taken |
| in_sample | input | 18 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes output sample |
| out_sample | output | 18 | Signed scaled sample |

## Verification
Several properties are checked on every cycle:
- the code never moves in a cycle without a tick;
- each change of the code is a single-code step or one of the permitted jumps across the silence boundary;
- the code cannot rise while mute is held;
- a sample taken at silence comes out as zero;
- a stalled output holds its value.

Other behaviour only shows up through scenarios in the bench:
- the exact step counts for each interval, and the restart of that count on a target change;
- the return to the stored level after mute and after sync loss;
- the value pinned in fixed mode;
- the numeric gain values, including saturation at +3 dB and the floor rounding of negative samples.

// File: rtl/ramp_atten_pkg.sv
package ramp_atten_pkg;
  localparam int CODE_W = 7;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t SILENT_MAX    = 7'h14;
  localparam code_t FIRST_AUDIBLE = 7'h15;
  localparam code_t UNITY_CODE    = 7'h79;
  localparam code_t SILENT_CODE   = 7'h00;
  localparam int    TOP_CODE      = (1 << CODE_W) - 1;
  localparam int    DB_PER_SHIFT  = 6;

  function automatic logic is_silent(input code_t c);
    return c <= SILENT_MAX;
  endfunction
endpackage

// File: rtl/ramp_step_timer.sv
module ramp_step_timer #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [STEP_W-1:0] step_sel,
  output logic              step_fire
);
  localparam int CNT_W = (1 << STEP_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = '0;
    for (int i = 0; i < CNT_W; i++) begin
      limit[i] = (i < int'(step_sel));
    end
  end

  assign step_fire = tick && !restart && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= limit) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ramp_level_ctrl.sv
module ramp_level_ctrl
  import ramp_atten_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t level_target,
  input  logic  mute_req,
  input  logic  sync_ok,
  input  logic  fixed_unity,
  input  logic  step_fire,
  output logic  restart,
  output code_t level_code
);
  code_t eff_tgt;
  code_t last_tgt_q;
  code_t cur_q;
  code_t cur_d;

  always_comb begin
    if (mute_req || !sync_ok) eff_tgt = SILENT_CODE;
    else if (fixed_unity)     eff_tgt = UNITY_CODE;
    else                      eff_tgt = level_target;
  end

  assign restart = (eff_tgt != last_tgt_q);

  always_comb begin
    cur_d = cur_q;
    if (step_fire && (cur_q != eff_tgt)) begin
      if (is_silent(cur_q) && is_silent(eff_tgt)) begin
        cur_d = eff_tgt;
      end else if (cur_q < eff_tgt) begin
        cur_d = is_silent(cur_q) ? FIRST_AUDIBLE : cur_q + 1'b1;
      end else begin
        cur_d = is_silent(cur_q - 1'b1) ? eff_tgt : cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= SILENT_CODE;
      last_tgt_q <= SILENT_CODE;
    end else begin
      cur_q      <= cur_d;
      last_tgt_q <= eff_tgt;
    end
  end

  assign level_code = cur_q;
endmodule

// File: rtl/ramp_gain_stage.sv
module ramp_gain_stage
  import ramp_atten_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int MANT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  code_t                      code,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  localparam int PROD_W = SAMPLE_W + MANT_W + 1;
  localparam int FRAC_W = MANT_W - 1;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (SAMPLE_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = PROD_W'(-(64'sd1 <<< (SAMPLE_W-1)));

  code_t                      att;
  code_t                      oct;
  code_t                      rem;
  code_t                      sh;
  logic        [MANT_W-1:0]   mant;
  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   scaled;
  logic signed [SAMPLE_W-1:0] result;
  logic                       take;

  always_comb begin
    att = code_t'(TOP_CODE) - code;
    oct = att / code_t'(DB_PER_SHIFT);
    rem = att % code_t'(DB_PER_SHIFT);
    sh  = oct + code_t'(FRAC_W - 1);
    case (rem)
      7'd0:    mant = MANT_W'(32768);
      7'd1:    mant = MANT_W'(29205);
      7'd2:    mant = MANT_W'(26029);
      7'd3:    mant = MANT_W'(23198);
      7'd4:    mant = MANT_W'(20675);
      default: mant = MANT_W'(18427);
    endcase
    prod   = $signed(in_sample) * $signed({1'b0, mant});
    scaled = prod >>> sh;
    if (is_silent(code))     result = '0;
    else if (scaled > SAT_HI) result = SAT_HI[SAMPLE_W-1:0];
    else if (scaled < SAT_LO) result = SAT_LO[SAMPLE_W-1:0];
    else                      result = scaled[SAMPLE_W-1:0];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_sample <= result;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ramp_atten.sv
module ramp_atten
  import ramp_atten_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int STEP_W   = 3,
  parameter int MANT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_tick,
  input  logic [CODE_W-1:0]          level_target,
  input  logic [STEP_W-1:0]          step_sel,
  input  logic                       mute_req,
  input  logic                       sync_ok,
  input  logic                       fixed_unity,
  output logic [CODE_W-1:0]          level_code,
  output logic                       level_silent,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  logic  step_fire;
  logic  restart;
  code_t code;

  ramp_step_timer #(.STEP_W(STEP_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .restart   (restart),
    .step_sel  (step_sel),
    .step_fire (step_fire)
  );

  ramp_level_ctrl level_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_target (level_target),
    .mute_req     (mute_req),
    .sync_ok      (sync_ok),
    .fixed_unity  (fixed_unity),
    .step_fire    (step_fire),
    .restart      (restart),
    .level_code   (code)
  );

  ramp_gain_stage #(.SAMPLE_W(SAMPLE_W), .MANT_W(MANT_W)) gain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (code),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample)
  );

  assign level_code   = code;
  assign level_silent = is_silent(code);
endmodule

// File: rtl/ramp_atten_chk.sv
module ramp_atten_chk #(
  parameter int SAMPLE_W = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_tick,
  input logic                mute_req,
  input logic [6:0]          level_code,
  input logic                level_silent,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample
);
  p_no_tick_no_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(level_code));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_code) |->
      (level_code == $past(level_code) + 7'd1) ||
      (level_code == $past(level_code) - 7'd1) ||
      ($past(level_code) <= 7'h14 && level_code <= 7'h15) ||
      ($past(level_code) == 7'h15 && level_code <= 7'h14));

  p_mute_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> level_code <= $past(level_code));

  p_silent_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && level_silent) |=> (out_sample == '0));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  p_stall_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind ramp_atten ramp_atten_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_tick  (sample_tick),
  .mute_req     (mute_req),
  .level_code   (level_code),
  .level_silent (level_silent),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sample   (out_sample)
);

// File: tb/ramp_atten_tb_top.sv
module ramp_atten_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 1'b0;
  logic [6:0]  level_target = '0;
  logic [2:0]  step_sel = '0;
  logic        mute_req = 1'b0;
  logic        sync_ok = 1'b1;
  logic        fixed_unity = 1'b0;
  logic [6:0]  level_code;
  logic        level_silent;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic signed [17:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic signed [17:0] out_sample;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ramp_atten dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .level_target(level_target), .step_sel(step_sel), .mute_req(mute_req),
    .sync_ok(sync_ok), .fixed_unity(fixed_unity), .level_code(level_code),
    .level_silent(level_silent), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample)
  );

  function automatic int gain_ref(int s, int code);
    int att, q, r;
    longint m, p;
    if (code <= 20) return 0;
    att = 127 - code;
    q = att / 6;
    r = att % 6;
    case (r)
      0: m = 32768; 1: m = 29205; 2: m = 26029;
      3: m = 23198; 4: m = 20675; default: m = 18427;
    endcase
    p = (longint'(s) * m) >>> (14 + q);
    if (p > 131071) p = 131071;
    if (p < -131072) p = -131072;
    return int'(p);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic send(int s, int code, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 18'(s);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(gain_ref(s, code));
    tag_q.push_back(req);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor: pops expected items as the design hands them over
  initial begin
    forever begin
      @(negedge clk); #2;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected output", 1, 0);
        end else begin
          check(tag_q.pop_front(), int'(out_sample), exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R3 reset state
    check("R3 code", int'(level_code), 0);
    check("R3 silent", int'(level_silent), 1);
    // R2 silence flag at low code
    check("R2 silent at 0", int'(level_silent), 1);

    // R4 fixed mode, R5 jump out of silence
    step_sel = 3'd0; level_target = 7'h30; fixed_unity = 1'b1;
    settle();
    ticks(1);
    check("R5 jump to 0x15", int'(level_code), 'h15);
    check("R2 audible flag", int'(level_silent), 0);
    ticks(1);
    check("R5 single step", int'(level_code), 'h16);
    ticks(99);
    check("R4 fixed unity reached", int'(level_code), 'h79);
    ticks(3);
    check("R4 level_target ignored", int'(level_code), 'h79);

    // R1/R9 gain at unity
    send(1000, 'h79, "R1 unity 1000");
    send(-777, 'h79, "R1 unity -777");
    send(131071, 'h79, "R9 unity full scale");

    // R6 step interval 4 ticks
    fixed_unity = 1'b0; level_target = 7'h7C; step_sel = 3'd2;
    settle();
    ticks(3);
    check("R6 no step before 4 ticks", int'(level_code), 'h79);
    ticks(1);
    check("R6 step on 4th tick", int'(level_code), 'h7A);
    ticks(8);
    check("R6 target reached", int'(level_code), 'h7C);
    send(100000, 'h7C, "R9 saturate +3dB");
    send(-5000, 'h7C, "R9 floor negative +3dB");

    // R12 restart on target change
    level_target = 7'h70;
    settle();
    ticks(2);
    level_target = 7'h71;
    settle();
    ticks(3);
    check("R12 restart delays step", int'(level_code), 'h7C);
    ticks(1);
    check("R12 step after full interval", int'(level_code), 'h7B);
    send(20000, 'h7B, "R9 gain +2dB");

    // R7 mute ramp down and back
    step_sel = 3'd0; mute_req = 1'b1;
    settle();
    ticks(102);
    check("R7 down to 0x15", int'(level_code), 'h15);
    send(-3000, 'h15, "R9 gain -100dB");
    ticks(1);
    check("R7 muted code", int'(level_code), 0);
    check("R2 silent after mute", int'(level_silent), 1);
    send(12345, 0, "R10 zero at silence");
    mute_req = 1'b0;
    settle();
    ticks(1);
    check("R7 release jump", int'(level_code), 'h15);
    ticks(92);
    check("R7 back to set value", int'(level_code), 'h71);

    // R8 sync loss
    sync_ok = 1'b0;
    settle();
    ticks(93);
    check("R8 silent on sync loss", int'(level_code), 0);
    sync_ok = 1'b1;
    settle();
    ticks(93);
    check("R8 back after sync", int'(level_code), 'h71);

    // R11 back-pressure
    level_target = 7'h79;
    settle();
    ticks(8);
    check("R1 unity again", int'(level_code), 'h79);
    out_ready = 1'b0;
    send(4321, 'h79, "R11 first held");
    in_valid = 1'b1; in_sample = 18'sd1234;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R11 in_ready low", int'(in_ready), 0);
      check("R11 out held", int'(out_sample), 4321);
    end
    exp_q.push_back(1234);
    tag_q.push_back("R11 second after stall");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule